// File: doc/BRIEF.md
# Serial Commit Write Buffer

This block is a per-core store buffer for optimistic hardware transactions. Between a transaction's start and end, every store lands in a small fully associative buffer rather than in memory. Loads look in the buffer first. Each load address also sets one bit in a hashed read-set vector. To publish its updates, the core must hold a single system-wide commit token. While it holds the token, the buffer drives one beat per buffered update onto a shared broadcast bus. Other cores snoop that bus. If a snooped address falls on one of their own read-set bits, they abort.

A core that does not hold the token aborts as soon as a snooped address hits its read set. Software can also abort it. Either kind of abort empties the buffer and the read set in one cycle. When a store needs a new entry and the buffer is full, the transaction becomes irrevocable. It requests the token and stalls the store until the token arrives. From then on, stores that do not fit are written through onto the broadcast bus. Aborts and conflicts are ignored until the commit finishes. A separate round-robin arbiter hands out the token. The arbiter lives outside this block, and the bench models it.

Top module: `commitWriteBuffer`

## Requirements
- R1: After reset, tokenReq, bcValid, conflictAbort and ldHit are low and stReady is high.
- R2: A load to an address held in the buffer sets ldHit in the same cycle and returns the buffered data. A load that misses leaves ldHit low.
- R3: A store to an address that is already buffered overwrites that entry's data and allocates no new entry. At commit the address is broadcast exactly once, carrying the latest data.
- R4: When txEnd is accepted, tokenReq rises in the next cycle and stays high until tokenGrant is seen. bcValid stays low until then.
- R5: If the buffer holds N entries, the N beats appear on consecutive cycles in first-store order. The first beat comes in the cycle after the grant is sampled. tokenReq falls in the cycle after the last beat.
- R6: A commit with an empty buffer produces no beat, and tokenReq falls in the cycle after the grant is sampled.
- R7: While the token is not held, a snoop hits the read set when read-set bit addr[3:0] of the snoop address is set. On a hit, conflictAbort pulses for one cycle in the next cycle, tokenReq is low, and the buffer is emptied.
- R8: A snoop whose read-set bit is clear has no effect. The transaction and its buffered data continue.
- R9: txAbort empties the buffer in a single cycle, so a load in the next cycle misses.
- R10: A store that needs a new entry while all ENTRIES entries are in use drops stReady and raises tokenReq in the next cycle. After the grant is sampled, stReady returns and the store appears on the broadcast bus. From then on, txAbort and snoop hits are ignored, and txEnd broadcasts the buffered entries.
- R11: A snoop hit during the token holder's own broadcast is ignored. No abort occurs and the remaining beats follow.
- R12: Stores, loads and snoops outside a transaction change nothing in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Start a transaction |
| txEnd | input | 1 | Ask to commit the transaction |
| txAbort | input | 1 | Software abort |
| stValid | input | 1 | Speculative store request |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| stReady | output | 1 | Store accepted this cycle |
| ldValid | input | 1 | Load lookup request |
| ldAddr | input | ADDR_W | Load address |
| ldHit | output | 1 | Load hit in the buffer |
| ldData | output | DATA_W | Buffered data for a load hit |
| tokenReq | output | 1 | Commit token request |
| tokenGrant | input | 1 | Commit token granted |
| snoopValid | input | 1 | Another core's broadcast beat is valid |
| snoopAddr | input | ADDR_W | Address on another core's broadcast |
| bcValid | output | 1 | Broadcast beat valid |
| bcAddr | output | ADDR_W | Broadcast address |
| bcData | output | DATA_W | Broadcast data |
| conflictAbort | output | 1 | One-cycle pulse after a conflict abort |

## Verification
A corrupted entry count or entry table shows up on the first load to that address, which returns the wrong ldHit or ldData in the same cycle. At the latest, it shows up at the next commit, as a wrong number, order or content of beats. A stale read-set bit produces a spurious conflictAbort one cycle after an unrelated snoop. A lost bit produces a missing pulse. A wrong controller state shows within one or two cycles, as tokenReq out of step with txEnd, with the grant or with the last beat, or as stReady held low without a token request.

// File: rtl/cwbPkg.sv
package cwbPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_OVF_WAIT, ST_IRREV, ST_CMT_WAIT, ST_BCAST, ST_RELEASE
  } cwbState_t;

  typedef struct packed {
    logic clearAll;  // empty buffer and read set
    logic storeEn;   // merge or allocate the offered store
    logic loadEn;    // record load address in read set
    logic beatEn;    // drive a buffered entry onto the bus
    logic thruEn;    // drive the offered store straight onto the bus
  } cwbStrobes_t;
endpackage

// File: rtl/cwbDatapath.sv
module cwbDatapath
  import cwbPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 8,
  parameter int RS_BITS = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int RS_W   = $clog2(RS_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cwbStrobes_t       ctl,
  input  logic [IDX_W-1:0]  bcIdx,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              stHit,
  output logic              full,
  output logic [CNT_W-1:0]  count,
  output logic              rsHit,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData,
  output logic              bcValid,
  output logic [ADDR_W-1:0] bcAddr,
  output logic [DATA_W-1:0] bcData
);
  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [DATA_W-1:0] dataQ [ENTRIES];
  logic [CNT_W-1:0]  countQ;
  logic [RS_BITS-1:0] rsQ;
  logic [IDX_W-1:0]  stIdx;
  logic              ldMatch;

  always_comb begin
    stHit   = 1'b0;
    stIdx   = '0;
    ldMatch = 1'b0;
    ldData  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (CNT_W'(i) < countQ) begin
        if (addrQ[i] == stAddr) begin
          stHit = 1'b1;
          stIdx = IDX_W'(i);
        end
        if (addrQ[i] == ldAddr) begin
          ldMatch = 1'b1;
          ldData  = dataQ[i];
        end
      end
    end
  end

  assign full    = (countQ == CNT_W'(ENTRIES));
  assign count   = countQ;
  assign rsHit   = rsQ[snoopAddr[RS_W-1:0]];
  assign ldHit   = ldValid & ldMatch;
  assign bcValid = ctl.beatEn | ctl.thruEn;
  assign bcAddr  = ctl.thruEn ? stAddr : addrQ[bcIdx];
  assign bcData  = ctl.thruEn ? stData : dataQ[bcIdx];

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      countQ <= '0;
      rsQ    <= '0;
    end else begin
      if (ctl.storeEn && !stHit && !full) countQ <= countQ + 1'b1;
      if (ctl.loadEn) rsQ[ldAddr[RS_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.storeEn && !ctl.clearAll) begin
      if (stHit) begin
        dataQ[stIdx] <= stData;
      end else if (!full) begin
        addrQ[countQ[IDX_W-1:0]] <= stAddr;
        dataQ[countQ[IDX_W-1:0]] <= stData;
      end
    end
  end
endmodule

// File: rtl/cwbControl.sv
module cwbControl
  import cwbPkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txBegin,
  input  logic             txEnd,
  input  logic             txAbort,
  input  logic             stValid,
  input  logic             ldValid,
  input  logic             snoopValid,
  input  logic             tokenGrant,
  input  logic             stHit,
  input  logic             full,
  input  logic [CNT_W-1:0] count,
  input  logic             rsHit,
  output cwbStrobes_t      ctl,
  output logic [IDX_W-1:0] bcIdx,
  output logic             tokenReq,
  output logic             stReady,
  output logic             conflictAbort
);
  cwbState_t state, nxt;
  logic conflictHit, abortReq, stallStore, lastBeat;

  assign stallStore = stValid & !stHit & full;
  assign conflictHit = snoopValid & rsHit &
    (state == ST_RUN || state == ST_OVF_WAIT || state == ST_CMT_WAIT);
  assign abortReq = conflictHit |
    (txAbort & (state == ST_RUN || state == ST_OVF_WAIT || state == ST_CMT_WAIT));
  assign lastBeat = (CNT_W'(bcIdx) == count - 1'b1);
  assign tokenReq = (state == ST_OVF_WAIT) || (state == ST_IRREV) ||
                    (state == ST_CMT_WAIT) || (state == ST_BCAST);

  always_comb begin
    ctl     = '0;
    nxt     = state;
    stReady = 1'b1;
    if (abortReq) begin
      ctl.clearAll = 1'b1;
      nxt          = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (txBegin) begin
          ctl.clearAll = 1'b1;
          nxt          = ST_RUN;
        end
        ST_RUN: begin
          ctl.loadEn = ldValid;
          if (stallStore) begin
            stReady = 1'b0;
            nxt     = ST_OVF_WAIT;
          end else begin
            ctl.storeEn = stValid;
            if (txEnd) nxt = ST_CMT_WAIT;
          end
        end
        ST_OVF_WAIT: begin
          stReady    = 1'b0;
          ctl.loadEn = ldValid;
          if (tokenGrant) nxt = ST_IRREV;
        end
        ST_IRREV: begin
          ctl.loadEn  = ldValid;
          ctl.storeEn = stValid;
          ctl.thruEn  = stallStore;
          if (txEnd) nxt = (count == '0) ? ST_RELEASE : ST_BCAST;
        end
        ST_CMT_WAIT: if (tokenGrant) nxt = (count == '0) ? ST_RELEASE : ST_BCAST;
        ST_BCAST: begin
          ctl.beatEn = 1'b1;
          if (lastBeat) nxt = ST_RELEASE;
        end
        ST_RELEASE: begin
          ctl.clearAll = 1'b1;
          nxt          = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      bcIdx         <= '0;
      conflictAbort <= 1'b0;
    end else begin
      state         <= nxt;
      bcIdx         <= (state == ST_BCAST) ? bcIdx + 1'b1 : '0;
      conflictAbort <= conflictHit;
    end
  end
endmodule

// File: rtl/commitWriteBuffer.sv
module commitWriteBuffer
  import cwbPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 8,
  parameter int RS_BITS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txEnd,
  input  logic              txAbort,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  output logic              stReady,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHit,
  output logic [DATA_W-1:0] ldData,
  output logic              tokenReq,
  input  logic              tokenGrant,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              bcValid,
  output logic [ADDR_W-1:0] bcAddr,
  output logic [DATA_W-1:0] bcData,
  output logic              conflictAbort
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  cwbStrobes_t      ctl;
  logic [IDX_W-1:0] bcIdx;
  logic [CNT_W-1:0] count;
  logic             stHit, full, rsHit;

  cwbControl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd), .txAbort(txAbort),
    .stValid(stValid), .ldValid(ldValid), .snoopValid(snoopValid),
    .tokenGrant(tokenGrant), .stHit(stHit), .full(full), .count(count),
    .rsHit(rsHit), .ctl(ctl), .bcIdx(bcIdx), .tokenReq(tokenReq),
    .stReady(stReady), .conflictAbort(conflictAbort)
  );

  cwbDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .RS_BITS(RS_BITS)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bcIdx(bcIdx), .stAddr(stAddr), .stData(stData),
    .ldValid(ldValid), .ldAddr(ldAddr), .snoopAddr(snoopAddr), .stHit(stHit),
    .full(full), .count(count), .rsHit(rsHit), .ldHit(ldHit), .ldData(ldData),
    .bcValid(bcValid), .bcAddr(bcAddr), .bcData(bcData)
  );
endmodule

// File: rtl/cwbChecker.sv
module cwbChecker (
  input logic clk,
  input logic rstN,
  input logic txAbort,
  input logic snoopValid,
  input logic stReady,
  input logic ldHit,
  input logic tokenReq,
  input logic bcValid,
  input logic conflictAbort
);
  // R5
  bcast_needs_token_chk: assert property (@(posedge clk) disable iff (!rstN)
    bcValid |-> tokenReq);

  // R7
  abort_follows_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflictAbort |-> $past(snoopValid));

  // R7
  abort_empties_buffer_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflictAbort |-> (!ldHit && !tokenReq));

  // R10
  stall_requests_token_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stReady && !txAbort && !snoopValid) |=> tokenReq);

  // R7
  abort_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflictAbort |=> !conflictAbort);
endmodule

bind commitWriteBuffer cwbChecker uChk (.*);

// File: tb/tb_commitWriteBuffer.sv
module tb_commitWriteBuffer;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic txBegin = 0, txEnd = 0, txAbort = 0, stValid = 0, ldValid = 0;
  logic tokenGrant = 0, snoopValid = 0;
  logic [15:0] stAddr = 0, ldAddr = 0, snoopAddr = 0;
  logic [31:0] stData = 0;
  logic stReady, ldHit, tokenReq, bcValid, conflictAbort;
  logic [31:0] ldData, bcData;
  logic [15:0] bcAddr;

  int nChecks = 0, nFails = 0;
  logic [15:0] refAddr [ENTRIES];
  logic [31:0] refData [ENTRIES];
  int refCnt = 0;
  logic [15:0] refRs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  commitWriteBuffer dut (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd), .txAbort(txAbort),
    .stValid(stValid), .stAddr(stAddr), .stData(stData), .stReady(stReady),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldHit(ldHit), .ldData(ldData),
    .tokenReq(tokenReq), .tokenGrant(tokenGrant), .snoopValid(snoopValid),
    .snoopAddr(snoopAddr), .bcValid(bcValid), .bcAddr(bcAddr), .bcData(bcData),
    .conflictAbort(conflictAbort)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int findIdx(input logic [15:0] a);
    for (int i = 0; i < refCnt; i++) if (refAddr[i] == a) return i;
    return -1;
  endfunction

  function automatic void clearModel();
    refCnt = 0;
    refRs = '0;
  endfunction

  task automatic beginTx();
    txBegin = 1;
    @(negedge clk);
    txBegin = 0;
    clearModel();
  endtask

  task automatic storeOp(input logic [15:0] a, input logic [31:0] d);
    int k;
    k = findIdx(a);
    stValid = 1; stAddr = a; stData = d;
    #1 check(stReady == 1'b1, "R3 stReady", stReady, 1);
    @(negedge clk);
    stValid = 0;
    if (k >= 0) refData[k] = d;
    else begin refAddr[refCnt] = a; refData[refCnt] = d; refCnt++; end
  endtask

  task automatic loadOp(input logic [15:0] a, input string req);
    int k;
    k = findIdx(a);
    ldValid = 1; ldAddr = a;
    #1;
    check(ldHit == (k >= 0), req, ldHit, (k >= 0));
    if (k >= 0) check(ldData == refData[k], req, ldData, refData[k]);
    @(negedge clk);
    ldValid = 0;
    refRs[a[3:0]] = 1'b1;
  endtask

  task automatic snoopOp(input logic [15:0] a, output bit hit);
    hit = refRs[a[3:0]];
    snoopValid = 1; snoopAddr = a;
    @(negedge clk);
    snoopValid = 0;
    check(conflictAbort == hit, hit ? "R7 conflict" : "R8 no conflict", conflictAbort, hit);
    if (hit) begin
      check(tokenReq == 1'b0, "R7 tokenReq", tokenReq, 0);
      clearModel();
    end
  endtask

  // commit: optional snoop injected during first beat (R11)
  task automatic commitTx(input int delay, input bit snoopInBeat, input logic [15:0] sa);
    txEnd = 1;
    @(negedge clk);
    txEnd = 0;
    check(tokenReq == 1'b1, "R4 request", tokenReq, 1);
    check(bcValid == 1'b0, "R4 no beat before grant", bcValid, 0);
    for (int w = 0; w < delay; w++) begin
      @(negedge clk);
      check(tokenReq && !bcValid, "R4 waiting", {tokenReq, bcValid}, 2'b10);
    end
    tokenGrant = 1;
    @(negedge clk);
    for (int i = 0; i < refCnt; i++) begin
      check(bcValid == 1'b1, "R5 beat valid", bcValid, 1);
      check(bcAddr == refAddr[i], "R5 beat addr", bcAddr, refAddr[i]);
      check(bcData == refData[i], "R3 beat data", bcData, refData[i]);
      if (snoopInBeat && i == 0) begin snoopValid = 1; snoopAddr = sa; end
      @(negedge clk);
      snoopValid = 0;
      if (snoopInBeat && i == 0) check(conflictAbort == 1'b0, "R11 ignored snoop", conflictAbort, 0);
    end
    check(!tokenReq && !bcValid, refCnt == 0 ? "R6 release" : "R5 release",
          {tokenReq, bcValid}, 0);
    tokenGrant = 0;
    @(negedge clk);
    clearModel();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    bit hit;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1 check(!tokenReq && !bcValid && !conflictAbort && !ldHit && stReady,
             "R1 reset", {tokenReq, bcValid, conflictAbort, ldHit, stReady}, 1);
    @(negedge clk);

    // R12: traffic outside a transaction
    stValid = 1; stAddr = 16'h0005; stData = 32'hdead;
    @(negedge clk); stValid = 0;
    beginTx();
    loadOp(16'h0005, "R12 idle store ignored");
    commitTx(0, 0, 0);

    // R3/R2 merge and forwarding
    beginTx();
    storeOp(16'h0010, 32'h1111);
    storeOp(16'h0010, 32'h2222);
    storeOp(16'h0020, 32'h3333);
    loadOp(16'h0010, "R2 load hit");
    loadOp(16'h0030, "R2 load miss");
    commitTx(2, 0, 0);

    // R6 empty commit
    beginTx();
    commitTx(1, 0, 0);

    // R7 conflict
    beginTx();
    loadOp(16'h0033, "R2 load");
    storeOp(16'h0040, 32'h4444);
    snoopOp(16'h1233, hit);
    loadOp(16'h0040, "R7 buffer emptied");

    // R8 harmless snoop
    beginTx();
    storeOp(16'h0041, 32'h5555);
    loadOp(16'h0001, "R2 load");
    snoopOp(16'h0002, hit);
    loadOp(16'h0041, "R8 data kept");
    commitTx(0, 0, 0);

    // R9 software abort
    beginTx();
    storeOp(16'h0050, 32'h6666);
    txAbort = 1; @(negedge clk); txAbort = 0;
    clearModel();
    loadOp(16'h0050, "R9 abort empties");

    // R11 snoop during own broadcast
    beginTx();
    loadOp(16'h0009, "R2 load");
    storeOp(16'h0060, 32'h7777);
    storeOp(16'h0061, 32'h8888);
    commitTx(1, 1, 16'h0009);

    // R10 overflow becomes irrevocable
    beginTx();
    loadOp(16'h000a, "R2 load");
    for (int i = 0; i < ENTRIES; i++) storeOp(16'h0100 + 16'(i), 32'h100 + 32'(i));
    stValid = 1; stAddr = 16'h0200; stData = 32'habcd;
    #1 check(stReady == 1'b0, "R10 stall", stReady, 0);
    @(negedge clk);
    check(tokenReq && !stReady, "R10 request", {tokenReq, stReady}, 2'b10);
    tokenGrant = 1;
    @(negedge clk);
    check(stReady && bcValid && bcAddr == 16'h0200 && bcData == 32'habcd,
          "R10 write-through", {stReady, bcValid, bcAddr, bcData}, {2'b11, 16'h0200, 32'habcd});
    stValid = 0;
    txAbort = 1; snoopValid = 1; snoopAddr = 16'h000a;
    @(negedge clk);
    txAbort = 0; snoopValid = 0;
    @(negedge clk);
    check(tokenReq && !conflictAbort, "R10 abort ignored", {tokenReq, conflictAbort}, 2'b10);
    loadOp(16'h0103, "R10 buffer kept");
    txEnd = 1; @(negedge clk); txEnd = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      check(bcValid && bcAddr == refAddr[i], "R10 drain", bcAddr, refAddr[i]);
      @(negedge clk);
    end
    check(!tokenReq, "R10 release", tokenReq, 0);
    tokenGrant = 0;
    @(negedge clk);
    clearModel();

    // random transactions
    for (int t = 0; t < 60; t++) begin
      bit dead;
      dead = 0;
      beginTx();
      for (int o = 0; o < 12 && !dead; o++) begin
        int r;
        logic [15:0] a;
        r = $urandom_range(0, 9);
        a = 16'($urandom_range(0, 40));
        if (r < 5) begin
          if (findIdx(a) >= 0 || refCnt < ENTRIES) storeOp(a, $urandom);
        end else if (r < 8) loadOp(a, "R2 random load");
        else if (r < 9) begin
          snoopOp(16'($urandom_range(0, 255)), hit);
          dead = hit;
        end else if ($urandom_range(0, 3) == 0) begin
          txAbort = 1; @(negedge clk); txAbort = 0;
          clearModel();
          loadOp(16'h0000, "R9 random abort");
          dead = 1;
        end
      end
      if (!dead) commitTx($urandom_range(0, 3), 0, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule